// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM's contents alive. It issues one refresh operation per row interval, so that all 2048 rows are refreshed within the retention window. The interval is taken from a clock-rate parameter. A free-running timer produces a refresh tick. A pending counter keeps track of ticks that have not been served. A small sequencer drives the row and column strobes while the block owns the memory bus.

Two refresh styles can be selected. In column-strobe-first mode, CAS is pulled low before RAS. The memory's own counter then picks the row, so the address bus stays at zero. In row-strobe-only mode, CAS stays high and the block drives a row number from its own 11-bit counter while RAS is low. The strobe bus is shared with a normal access controller. The scheduler raises a request, and it starts a cycle only once the grant is given. While the grant is held back, up to eight refreshes are kept pending, and an urgent flag rises when that limit is reached.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held and right after it, req=0, rasN=1, casN=1, addr=0, done=0 and urgent=0.
- R2: With extPeriod=0, a refresh becomes pending every STD cycles. STD is EXT/4 with integer division, and EXT = CLK_MHZ*125/2 cycles, which is 62.5 µs. After reset, req first reads high after exactly STD rising edges when no grant is given.
- R3: With extPeriod=1, a refresh becomes pending every EXT cycles. After reset, req first reads high after exactly EXT rising edges.
- R4: req is high whenever a refresh is pending or a cycle is in progress. A cycle starts only on an edge where the block is idle, a refresh is pending and grant=1. While grant=0, rasN and casN stay high.
- R5: With useCbr=1, a cycle consists of 1 cycle with casN=0 and rasN=1, then T_RAS cycles with both low, then T_RP cycles with both high. addr stays 0 throughout.
- R6: With useCbr=0, a cycle consists of T_RAS cycles with rasN=0 and casN=1, with addr equal to the internal row counter, then T_RP cycles with both high.
- R7: The row counter starts at 0. It advances by one only when a row-strobe-only cycle completes, and it wraps from 2047 to 0. Column-strobe-first cycles leave it unchanged.
- R8: At most MAX_PEND=8 refreshes are held pending. urgent is 1 exactly while 8 are pending. Ticks that arrive at the limit are dropped. Once granted, the pending refreshes are served back to back.
- R9: done is high for exactly one cycle, the last precharge cycle of each refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| useCbr | input | 1 | 1 selects column-strobe-first refresh, 0 selects row-strobe-only; sampled when a cycle starts |
| extPeriod | input | 1 | 1 selects the long retention interval |
| grant | input | 1 | Bus grant from the access controller |
| req | output | 1 | Bus request |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| addr | output | ROW_BITS | Row address during row-strobe-only cycles, otherwise 0 |
| done | output | 1 | One-cycle pulse at the end of each refresh |
| urgent | output | 1 | Pending refreshes at the limit |

## Verification
The interval is measured after reset in both period settings. This separates the standard divider from the extended one and exposes any off-by-one error in the tick position. Cycles of the two refresh styles are interleaved under a single reset. This shows whether each strobe waveform is right and whether only row-strobe-only completions move the row counter. A run with the grant held back for nine intervals tells the urgent rise and the saturation apart from unlimited counting, because the back-to-back drain must give exactly eight done pulses. A long run with the grant always given walks the row address through all 2048 rows and confirms that it wraps to 0.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  typedef struct packed {
    logic rasLow;
    logic casLow;
    logic rowDrive;
    logic advance;
  } refStrobe_t;
endpackage

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int T_RAS    = 3,
  parameter int T_RP     = 2,
  parameter int MAX_PEND = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       useCbr,
  input  logic       extPeriod,
  input  logic       grant,
  output logic       req,
  output logic       done,
  output logic       urgent,
  output refStrobe_t strb
);
  localparam int EXT_CYC = (CLK_MHZ * 125) / 2;
  localparam int STD_CYC = EXT_CYC / 4;
  localparam int TW = $clog2(EXT_CYC + 1);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam int PH_MAX = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int HW = $clog2(PH_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_CASLEAD, S_RASLO, S_PRECH} state_t;

  state_t state, nextState;
  logic [TW-1:0] tmr;
  logic [TW-1:0] interval;
  logic [PW-1:0] pend;
  logic [HW-1:0] ph;
  logic tick, start, cycCbr;

  assign interval = extPeriod ? TW'(EXT_CYC) : TW'(STD_CYC);
  assign tick = (tmr >= interval - TW'(1));
  assign start = (state == S_IDLE) && (pend != '0) && grant;

  always_ff @(posedge clk) begin
    if (!rstN) tmr <= '0;
    else if (tick) tmr <= '0;
    else tmr <= tmr + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) pend <= '0;
    else begin
      case ({tick, start})
        2'b10: if (pend != PW'(MAX_PEND)) pend <= pend + PW'(1);
        2'b01: pend <= pend - PW'(1);
        default: pend <= pend;
      endcase
    end
  end

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE:    if (start) nextState = useCbr ? S_CASLEAD : S_RASLO;
      S_CASLEAD: nextState = S_RASLO;
      S_RASLO:   if (ph == HW'(T_RAS - 1)) nextState = S_PRECH;
      S_PRECH:   if (ph == HW'(T_RP - 1)) nextState = S_IDLE;
      default:   nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      ph     <= '0;
      cycCbr <= 1'b0;
    end else begin
      state <= nextState;
      ph    <= (nextState != state) ? '0 : ph + HW'(1);
      if (start) cycCbr <= useCbr;
    end
  end

  assign done          = (state == S_PRECH) && (ph == HW'(T_RP - 1));
  assign req           = (state != S_IDLE) || (pend != '0);
  assign urgent        = (pend == PW'(MAX_PEND));
  assign strb.rasLow   = (state == S_RASLO);
  assign strb.casLow   = (state == S_CASLEAD) || ((state == S_RASLO) && cycCbr);
  assign strb.rowDrive = (state == S_RASLO) && !cycCbr;
  assign strb.advance  = done && !cycCbr;

  // R5: CAS already low the cycle before RAS falls in a CBR cycle
  a_r5_cas_before_ras: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rasLow && !$past(strb.rasLow) && strb.casLow) |-> $past(strb.casLow));

  // R8: pending count holds at its limit unless a cycle starts
  a_r8_sat_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pend) == PW'(MAX_PEND) && !$past(start)) |-> (pend == PW'(MAX_PEND)));

  // R9: done never lasts two cycles
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: strobes idle unless a cycle was started
  a_r4_idle_strobes: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == S_IDLE && !$past(start)) |-> (!strb.rasLow && !strb.casLow));
endmodule

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int ROW_BITS = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  refStrobe_t          strb,
  output logic                rasN,
  output logic                casN,
  output logic [ROW_BITS-1:0] addr
);
  logic [ROW_BITS-1:0] row;

  always_ff @(posedge clk) begin
    if (!rstN) row <= '0;
    else if (strb.advance) row <= row + ROW_BITS'(1);
  end

  assign rasN = !strb.rasLow;
  assign casN = !strb.casLow;
  assign addr = strb.rowDrive ? row : '0;

  // R7: row steps by one (wrapping) after each completed row-only cycle
  a_r7_row_step: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.advance) |-> (row == ROW_BITS'($past(row) + 1'b1)));

  // R7: row holds otherwise
  a_r7_row_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.advance) |-> $stable(row));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import refsched_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int T_RAS    = 3,
  parameter int T_RP     = 2,
  parameter int MAX_PEND = 8,
  parameter int ROW_BITS = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                useCbr,
  input  logic                extPeriod,
  input  logic                grant,
  output logic                req,
  output logic                rasN,
  output logic                casN,
  output logic [ROW_BITS-1:0] addr,
  output logic                done,
  output logic                urgent
);
  refStrobe_t strb;

  refsched_ctrl #(
    .CLK_MHZ(CLK_MHZ), .T_RAS(T_RAS), .T_RP(T_RP), .MAX_PEND(MAX_PEND)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .useCbr(useCbr), .extPeriod(extPeriod),
    .grant(grant), .req(req), .done(done), .urgent(urgent), .strb(strb)
  );

  refsched_dp #(.ROW_BITS(ROW_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rasN(rasN), .casN(casN), .addr(addr)
  );
endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int CLK_MHZ = 1;
  localparam int T_RAS = 3;
  localparam int T_RP = 2;
  localparam int MAX_PEND = 8;
  localparam int ROW_BITS = 11;
  localparam int EXT = (CLK_MHZ * 125) / 2;
  localparam int STD = EXT / 4;
  localparam int ROWS = 1 << ROW_BITS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic useCbr = 1'b1;
  logic extPeriod = 1'b0;
  logic grant = 1'b0;
  logic req, rasN, casN, done, urgent;
  logic [ROW_BITS-1:0] addr;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(
    .CLK_MHZ(CLK_MHZ), .T_RAS(T_RAS), .T_RP(T_RP),
    .MAX_PEND(MAX_PEND), .ROW_BITS(ROW_BITS)
  ) uut (
    .clk(clk), .rstN(rstN), .useCbr(useCbr), .extPeriod(extPeriod),
    .grant(grant), .req(req), .rasN(rasN), .casN(casN), .addr(addr),
    .done(done), .urgent(urgent)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic doReset(input bit ext, input bit cbr, input bit gnt);
    @(negedge clk);
    rstN = 1'b0; extPeriod = ext; useCbr = cbr; grant = gnt;
    step(2);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    doReset(1'b0, 1'b1, 1'b0);
    check(req == 0 && rasN == 1 && casN == 1 && addr == 0 && done == 0 && urgent == 0,
          "R1 reset outputs", {req, rasN, casN, done, urgent}, 5'b01100);
  endtask

  task automatic t_interval(input bit ext, input int expN);
    int n = 0;
    doReset(ext, 1'b1, 1'b0);
    while (n < 1000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (req) break;
    end
    if (ext) check(n == expN, "R3 extended interval", n, expN);
    else     check(n == expN, "R2 standard interval", n, expN);
  endtask

  task automatic waitReq();
    for (int i = 0; i < 500 && !req; i++) step(1);
  endtask

  task automatic runCycle(input bit cbr, input int expRow);
    useCbr = cbr;
    waitReq();
    grant = 1'b1;
    step(1);
    grant = 1'b0;
    if (cbr) begin
      check(casN == 0 && rasN == 1 && addr == 0, "R5 CAS lead", {casN, rasN}, 2'b01);
      step(1);
    end
    for (int i = 0; i < T_RAS; i++) begin
      if (cbr)
        check(rasN == 0 && casN == 0 && addr == 0 && !done, "R5 RAS low phase",
              {rasN, casN, done}, 3'b000);
      else begin
        check(rasN == 0 && casN == 1 && !done, "R6 RAS-only strobes", {rasN, casN, done}, 3'b010);
        check(int'(addr) == expRow, "R7 row address", addr, expRow);
      end
      step(1);
    end
    for (int i = 0; i < T_RP; i++) begin
      check(rasN == 1 && casN == 1, "R6 precharge strobes", {rasN, casN}, 2'b11);
      check(done == (i == T_RP - 1), "R9 done position", done, (i == T_RP - 1));
      step(1);
    end
    check(done == 0, "R9 done single cycle", done, 0);
  endtask

  task automatic t_holdoff();
    doReset(1'b0, 1'b1, 1'b0);
    waitReq();
    step(5);
    check(req == 1 && rasN == 1 && casN == 1, "R4 no cycle without grant",
          {req, rasN, casN}, 3'b111);
  endtask

  task automatic t_modes();
    doReset(1'b0, 1'b1, 1'b0);
    runCycle(1'b0, 0);
    runCycle(1'b1, 0);
    runCycle(1'b0, 1);
    runCycle(1'b1, 0);
    runCycle(1'b0, 2);
  endtask

  task automatic t_postpone();
    int dones = 0;
    doReset(1'b1, 1'b1, 1'b0);
    step(8 * EXT - 1);
    check(urgent == 0, "R8 urgent below limit", urgent, 0);
    step(1);
    check(urgent == 1, "R8 urgent at limit", urgent, 1);
    step(EXT + 2);
    check(urgent == 1 && req == 1, "R8 saturated", {urgent, req}, 2'b11);
    grant = 1'b1;
    step(1);
    check(urgent == 0, "R8 urgent clears on start", urgent, 1'b0);
    for (int i = 0; i < 200 && req; i++) begin
      if (done) dones++;
      step(1);
    end
    grant = 1'b0;
    check(dones == MAX_PEND, "R8 drained count", dones, MAX_PEND);
    check(req == 0, "R4 req drops when drained", req, 0);
  endtask

  task automatic t_wrap();
    doReset(1'b0, 1'b0, 1'b1);
    for (int k = 0; k <= ROWS; k++) begin
      for (int i = 0; i < 100 && rasN; i++) step(1);
      check(int'(addr) == (k % ROWS), "R7 row sequence/wrap", addr, k % ROWS);
      for (int i = 0; i < 100 && !rasN; i++) step(1);
    end
    grant = 1'b0;
  endtask

  initial begin
    t_reset();
    t_interval(1'b0, STD);
    t_interval(1'b1, EXT);
    t_holdoff();
    t_modes();
    t_postpone();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule